// File: doc/BRIEF.md
# Self-Timed Asynchronous Serial Port

This block is a full-duplex asynchronous serial port that has no programmed bit rate. It learns the bit period by timing low pulses on its receive line. The first character after reset trains it. Later characters retune it whenever a pulse one bit long is seen. Received bytes leave on a one-cycle valid strobe with an 8-bit data bus. Bytes to send enter on a valid/ready pair. The receive and transmit directions run at the same time on separate lines, and both use the measured period.

Each character is ten bits long: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Only periods that correspond to bit rates from BAUD_MIN to BAUD_MAX at a system clock of CLK_HZ are accepted. The transmitter stays silent until a period has been learned.

Top module: `abu_uart`

## Requirements
- R1: After reset, tx_line is high, tx_ready is low, and rx_valid and rx_ferr are low.
- R2: Before a period has been learned, tx_ready stays low and tx_line stays high, even while tx_valid is asserted.
- R3: While unlocked, the first low pulse on rx_line whose width W in clock cycles lies in MIN_DIV..MAX_DIV becomes the bit period and locks the port. Here MIN_DIV = ceil(CLK_HZ/BAUD_MAX) and MAX_DIV = floor(CLK_HZ/BAUD_MIN). Pulses outside that range leave the port unlocked.
- R4: Frame format: a start bit at 0, data bits 0 to 7 in that order, and a stop bit at 1. Each well-framed byte produces exactly one rx_valid pulse of one cycle, with the byte on rx_data.
- R5: The training character after reset, whose bit 0 must be 1, is also received and delivered.
- R6: If the stop bit is sampled as 0, rx_ferr pulses for one cycle and no rx_valid is given for that byte.
- R7: A byte is taken when tx_valid and tx_ready are both high. tx_line then sends start, data LSB first and stop, each exactly P cycles long, where P is the period held at acceptance. tx_ready stays low until the stop bit has ended.
- R8: Reception and transmission proceed at the same time without corrupting each other.
- R9: Once locked, a low pulse of width W with |W−P| < floor(P/2), and W inside MIN_DIV..MAX_DIV, replaces the period P with W.
- R10: Once locked, a low pulse that falls inside the one-bit window of R9 but outside MIN_DIV..MAX_DIV leaves P unchanged.
- R11: A start bit is confirmed by sampling floor(P/2) cycles after the falling edge, and every later bit is sampled one period after the bit before it. A low pulse that has already ended at the confirming sample produces no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| tx_line | output | 1 | Serial output, idle high |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_ferr | output | 1 | One-cycle strobe for a byte dropped on a bad stop bit |
| tx_valid | input | 1 | Byte offered for transmission |
| tx_data | input | 8 | Byte to transmit |
| tx_ready | output | 1 | Transmitter locked and idle |

## Verification
The bench builds the block with CLK_HZ = 4_000_000 and the default rate limits. The accepted period window therefore shrinks to 18..66 cycles, and a whole character takes only a few hundred cycles. This makes it practical to cover several things in one short run: rejecting a too-short and a too-long pulse before lock, training at 40 cycles per bit, and stepping the period down through 30, 24 and 20. At 20 cycles per bit, a 12-cycle pulse sits inside the one-bit window but below the range, and a 5-cycle pulse dies before the half-period sample.

// File: rtl/abu_pkg.sv
package abu_pkg;
  localparam int DATA_BITS = 8;
  localparam int IDX_W = $clog2(DATA_BITS);

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP
  } rx_state_t;
endpackage

// File: rtl/abu_period_meter.sv
module abu_period_meter #(
  parameter int MIN_DIV = 18,
  parameter int MAX_DIV = 66,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_s,
  output logic [DW-1:0] period,
  output logic          locked,
  output logic          lock_pulse
);
  localparam logic [DW-1:0] LO  = MIN_DIV[DW-1:0];
  localparam logic [DW-1:0] HI  = MAX_DIV[DW-1:0];
  localparam logic [DW-1:0] SAT = '1;

  logic          rx_d;
  logic [DW-1:0] wcnt;
  logic [DW-1:0] div_q;
  logic          lock_q;
  logic          lockp_q;

  logic          fall, rise, in_range, one_bit;
  logic [DW-1:0] half;

  always_comb begin
    fall     = rx_d & ~rx_s;
    rise     = ~rx_d & rx_s;
    half     = div_q >> 1;
    in_range = (wcnt >= LO) && (wcnt <= HI);
    one_bit  = (({1'b0, wcnt} + {1'b0, half}) > {1'b0, div_q}) &&
               ({1'b0, wcnt} < ({1'b0, div_q} + {1'b0, half}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_d    <= 1'b1;
      wcnt    <= '0;
      div_q   <= '0;
      lock_q  <= 1'b0;
      lockp_q <= 1'b0;
    end else begin
      rx_d    <= rx_s;
      lockp_q <= 1'b0;
      if (fall) begin
        wcnt <= {{(DW-1){1'b0}}, 1'b1};
      end else if (!rx_s && wcnt != SAT) begin
        wcnt <= wcnt + 1'b1;
      end
      if (rise && in_range && (!lock_q || one_bit)) begin
        div_q   <= wcnt;
        lock_q  <= 1'b1;
        lockp_q <= ~lock_q;
      end
    end
  end

  assign period     = div_q;
  assign locked     = lock_q;
  assign lock_pulse = lockp_q;

  p_div_in_range_r3: assert property (@(posedge clk) disable iff (rst)
    (div_q != $past(div_q)) |-> (div_q >= LO && div_q <= HI));

  p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    $past(lock_q) |-> lock_q);
endmodule

// File: rtl/abu_rx.sv
module abu_rx
  import abu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_s,
  input  logic [DW-1:0]        period,
  input  logic                 locked,
  input  logic                 lock_pulse,
  output logic                 valid,
  output logic [DATA_BITS-1:0] data,
  output logic                 ferr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_BITS - 1);

  rx_state_t            state;
  logic                 rx_d;
  logic [DW-1:0]        cnt;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] shreg;
  logic [DW-1:0]        half_m1;

  assign half_m1 = (period >> 1) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RX_IDLE;
      rx_d  <= 1'b1;
      cnt   <= '0;
      idx   <= '0;
      shreg <= '0;
      data  <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      rx_d  <= rx_s;
      valid <= 1'b0;
      ferr  <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (lock_pulse) begin
            state <= RX_DATA;
            idx   <= '0;
            cnt   <= half_m1;
          end else if (locked && rx_d && !rx_s) begin
            state <= RX_START;
            cnt   <= half_m1;
          end
        end
        RX_START: begin
          if (cnt == '0) begin
            if (!rx_s) begin
              state <= RX_DATA;
              idx   <= '0;
              cnt   <= period - 1'b1;
            end else begin
              state <= RX_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt == '0) begin
            shreg <= {rx_s, shreg[DATA_BITS-1:1]};
            cnt   <= period - 1'b1;
            if (idx == LAST) state <= RX_STOP;
            else             idx   <= idx + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            if (rx_s) begin
              valid <= 1'b1;
              data  <= shreg;
            end else begin
              ferr <= 1'b1;
            end
            state <= RX_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);

  p_ferr_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(valid && ferr));
endmodule

// File: rtl/abu_tx.sv
module abu_tx
  import abu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DW-1:0]        period,
  input  logic                 locked,
  input  logic                 tx_valid,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 tx_ready,
  output logic                 tx_line
);
  localparam int FRAME = DATA_BITS + 2;
  localparam int BW = $clog2(FRAME);
  localparam logic [BW-1:0] LAST = BW'(FRAME - 1);

  logic             busy;
  logic [FRAME-1:0] shf;
  logic [DW-1:0]    cnt;
  logic [DW-1:0]    per_q;
  logic [BW-1:0]    bitn;
  logic             line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      shf    <= '1;
      cnt    <= '0;
      per_q  <= '0;
      bitn   <= '0;
      line_q <= 1'b1;
    end else if (!busy) begin
      if (tx_valid && locked) begin
        busy   <= 1'b1;
        shf    <= {1'b1, tx_data, 1'b0};
        line_q <= 1'b0;
        cnt    <= period - 1'b1;
        per_q  <= period;
        bitn   <= '0;
      end
    end else if (cnt == '0) begin
      if (bitn == LAST) begin
        busy   <= 1'b0;
        line_q <= 1'b1;
      end else begin
        bitn   <= bitn + 1'b1;
        line_q <= shf[1];
        shf    <= {1'b1, shf[FRAME-1:1]};
        cnt    <= per_q - 1'b1;
      end
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  assign tx_ready = locked & ~busy;
  assign tx_line  = line_q;

  p_tx_idle_unlocked_r2: assert property (@(posedge clk) disable iff (rst)
    !locked |-> line_q);

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> !tx_ready);
endmodule

// File: rtl/abu_uart.sv
module abu_uart #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int BAUD_MIN = 60_000,
  parameter int BAUD_MAX = 234_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_line,
  output logic       tx_line,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_ferr,
  input  logic       tx_valid,
  input  logic [7:0] tx_data,
  output logic       tx_ready
);
  localparam int MIN_DIV = (CLK_HZ + BAUD_MAX - 1) / BAUD_MAX;
  localparam int MAX_DIV = CLK_HZ / BAUD_MIN;
  localparam int DW      = $clog2(2 * MAX_DIV + 1);

  logic [1:0]    sync_q;
  logic [DW-1:0] period;
  logic          locked, lock_pulse;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], rx_line};
  end

  abu_period_meter #(.MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV), .DW(DW)) meter_i (
    .clk(clk), .rst(rst), .rx_s(sync_q[1]),
    .period(period), .locked(locked), .lock_pulse(lock_pulse)
  );

  abu_rx #(.DW(DW)) rx_i (
    .clk(clk), .rst(rst), .rx_s(sync_q[1]), .period(period),
    .locked(locked), .lock_pulse(lock_pulse),
    .valid(rx_valid), .data(rx_data), .ferr(rx_ferr)
  );

  abu_tx #(.DW(DW)) tx_i (
    .clk(clk), .rst(rst), .period(period), .locked(locked),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_line(tx_line)
  );
endmodule

// File: tb/abu_uart_tb_top.sv
module abu_uart_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       tx_line, rx_valid, rx_ferr, tx_valid, tx_ready;
  logic [7:0] rx_data, tx_data;

  int n_chk = 0, n_fail = 0;
  int n_val = 0, n_ferr = 0;
  logic [7:0] last_rx = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  abu_uart #(.CLK_HZ(4_000_000)) dut_i (
    .clk(clk), .rst(rst), .rx_line(rx_line), .tx_line(tx_line),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ferr(rx_ferr),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (rx_valid) begin n_val++; last_rx = rx_data; end
      if (rx_ferr) n_ferr++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic idle(input int n);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(input int w);
    rx_line = 1'b0;
    repeat (w) @(negedge clk);
    rx_line = 1'b1;
  endtask

  task automatic send_rx(input logic [7:0] b, input int p, input bit stop);
    logic [9:0] fr = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      rx_line = fr[k];
      repeat (p) @(negedge clk);
    end
    idle(3 * p);
  endtask

  // Offers a byte and checks the serial frame and the start-bit width (R7)
  task automatic send_tx(input logic [7:0] b, input int p, input string req);
    logic [9:0] got = '0;
    int width = -1;
    int wait_n = 0;
    chk(tx_ready === 1'b1, {req, " tx_ready before offer"}, tx_ready, 1);
    tx_data = b; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    while (tx_line !== 1'b0 && wait_n < 50) begin @(negedge clk); wait_n++; end
    for (int i = 0; i < 10 * p; i++) begin
      if (i % p == p / 2) got[i / p] = tx_line;
      if (width < 0 && tx_line === 1'b1) width = i;
      @(negedge clk);
    end
    chk(got == {1'b1, b, 1'b0}, {req, " tx frame"}, got, {1'b1, b, 1'b0});
    if (b[0]) chk(width == p, {req, " tx start width"}, width, p);
    repeat (p) @(negedge clk);
    chk(tx_ready === 1'b1, {req, " tx_ready after frame"}, tx_ready, 1);
  endtask

  task automatic expect_rx(input logic [7:0] b, input int p, input string req);
    int v0 = n_val;
    send_rx(b, p, 1'b1);
    chk(n_val == v0 + 1, {req, " rx count"}, n_val - v0, 1);
    chk(last_rx == b, {req, " rx data"}, last_rx, b);
  endtask

  task automatic t_reset();
    chk(tx_line === 1'b1 && tx_ready === 1'b0 && rx_valid === 1'b0 && rx_ferr === 1'b0,
        "R1 reset outputs", {tx_line, tx_ready, rx_valid, rx_ferr}, 4'b1000);
  endtask

  task automatic t_refuse_unlocked();
    bit stayed_high = 1'b1;
    tx_data = 8'h00; tx_valid = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (tx_line !== 1'b1 || tx_ready !== 1'b0) stayed_high = 1'b0;
    end
    tx_valid = 1'b0;
    chk(stayed_high, "R2 no send before lock", stayed_high, 1);
  endtask

  task automatic t_reject_range();
    low_pulse(8);
    idle(100);
    chk(tx_ready === 1'b0, "R3 short pulse rejected", tx_ready, 0);
    low_pulse(80);
    idle(200);
    chk(tx_ready === 1'b0, "R3 long pulse rejected", tx_ready, 0);
  endtask

  task automatic t_train();
    expect_rx(8'h55, 40, "R5 training byte");
    chk(tx_ready === 1'b1, "R3 locked after training", tx_ready, 1);
  endtask

  task automatic t_rx_patterns();
    expect_rx(8'hA3, 40, "R4 pattern A3");
    expect_rx(8'h00, 40, "R4 pattern 00");
    expect_rx(8'hFF, 40, "R4 pattern FF");
  endtask

  task automatic t_tx_basic();
    send_tx(8'h2B, 40, "R7 at 40");
  endtask

  task automatic t_framing();
    int v0 = n_val, f0 = n_ferr;
    send_rx(8'h81, 40, 1'b0);
    chk(n_ferr == f0 + 1, "R6 ferr pulse", n_ferr - f0, 1);
    chk(n_val == v0, "R6 byte dropped", n_val - v0, 0);
    expect_rx(8'h5A, 40, "R6 recovery");
  endtask

  task automatic t_duplex();
    fork
      expect_rx(8'h3C, 40, "R8 duplex rx");
      send_tx(8'h6D, 40, "R8 duplex tx");
    join
  endtask

  task automatic t_refine();
    send_rx(8'h55, 30, 1'b1);
    expect_rx(8'hB7, 30, "R9 rx at 30");
    send_tx(8'hC5, 30, "R9 tx at 30");
    send_rx(8'h55, 24, 1'b1);
    send_rx(8'h55, 20, 1'b1);
    expect_rx(8'h3C, 20, "R9 rx at 20");
    send_tx(8'h01, 20, "R9 tx at 20");
  endtask

  task automatic t_glitches();
    int v0;
    low_pulse(12);
    idle(400);
    send_tx(8'h9F, 20, "R10 period kept");
    v0 = n_val;
    low_pulse(5);
    idle(300);
    chk(n_val == v0, "R11 short pulse no byte", n_val - v0, 0);
    send_tx(8'hE3, 20, "R11 period kept");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
      summary();
      $finish;
    end
  end

  initial begin
    tx_valid = 1'b0;
    tx_data  = 8'h00;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_refuse_unlocked();
    t_reject_range();
    t_train();
    t_rx_patterns();
    t_tx_basic();
    t_framing();
    t_duplex();
    t_refine();
    t_glitches();
    done = 1'b1;
    summary();
    $finish;
  end
endmodule